// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-stage (width set by a parameter) parallel-in, serial-out shift register that lives entirely inside one fast system clock domain. Its external control pins (two interchangeable shift clocks, an active-low load control, a serial data input and the parallel data word) are treated as sampled signals. Each passes through a synchroniser, and the shift clock is recovered by detecting rising edges of the OR of the two clock pins. No pin is ever used as a real clock.

While the load control is low, the register copies the parallel word on every system cycle, whatever the clock pins do. While it is high, the register either holds or, on a detected combined-clock rising edge, shifts one place from the first stage toward the last. During a shift the serial input enters the first stage. A clock pin held high blocks edges on the other one. The last stage is driven out both true and inverted, and a one-cycle pulse marks every shift that took place.

Top module: `psr_shift_top`

## Requirements
- R1: An active-low synchronous reset clears every stage to zero, so `last_q` reads 0, `last_qn` reads 1 and `shift_pulse` reads 0 after reset.
- R2: While `load_n` is low, stage i holds `par_in[i]` and follows later changes of the word. `last_q` is then `par_in[WIDTH-1]`. A pin change reaches the outputs on the third system clock edge after it is applied.
- R3: With `load_n` high, a rising edge of one clock pin while the other is low shifts the register once. Stage 0 takes `ser_in`, and each stage k+1 takes the old value of stage k.
- R4: While either clock pin is held high, edges on the other pin cause no shift. A falling edge of one pin while the other is high also causes no shift.
- R5: With `load_n` high and no qualifying clock edge, all stages keep their values, whatever `par_in` and `ser_in` do.
- R6: `last_qn` is always the inverse of `last_q`.
- R7: `shift_pulse` is high for exactly one system cycle for each shift and never rises during a load.
- R8: Load has priority. A clock edge detected while `load_n` is low is ignored, and the parallel word is kept.
- R9: After a load followed by WIDTH-1 shifts, `last_q` has presented `par_in[WIDTH-1]`, then `par_in[WIDTH-2]`, and so on down to `par_in[0]`. The first serial bit shifted in reaches `last_q` after WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_clk_a | input | 1 | Shift clock pin A (interchangeable with B) |
| tap_clk_b | input | 1 | Shift clock pin B (interchangeable with A) |
| load_n | input | 1 | Low: load parallel word; high: hold or shift |
| ser_in | input | 1 | Serial data into the first stage |
| par_in | input | WIDTH | Parallel word, bit i to stage i |
| last_q | output | 1 | Last stage, true |
| last_qn | output | 1 | Last stage, inverted |
| shift_pulse | output | 1 | One-cycle marker per shift |

## Verification
The properties assume that each pin stays steady for several system cycles around every change. Under that assumption the synchronised copies of a word and of its control arrive together, and the serial bit sampled at a detected edge is the one meant for it. The directed stimulus changes pins only on falling system clock edges. It keeps every level for at least four cycles, and it sets `ser_in` four cycles before raising a clock pin. Skew between synchroniser lanes therefore never appears in a check.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int unsigned MIN_SYNC = 2;
   localparam int unsigned MIN_WIDTH = 2;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } psr_op_e;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < psr_pkg::MIN_SYNC) begin : g_bad_stages
      $error("psr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/psr_edge.sv
module psr_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ca,
   input  logic cb,
   output logic rise
);
   logic comb_now;
   logic comb_prev;

   assign comb_now = ca | cb;

   always_ff @(posedge clk) begin
      if (!rst_n) comb_prev <= 1'b1;
      else        comb_prev <= comb_now;
   end

   assign rise = comb_now & ~comb_prev;
endmodule

// File: rtl/psr_stages.sv
module psr_stages
   import psr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             edge_hit,
   input  logic             ser,
   input  logic [WIDTH-1:0] par,
   output logic [WIDTH-1:0] stages,
   output logic             shifted
);
   psr_op_e op;

   always_comb begin
      if (!load_n)       op = OP_LOAD;
      else if (edge_hit) op = OP_SHIFT;
      else               op = OP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stages  <= '0;
         shifted <= 1'b0;
      end else begin
         shifted <= (op == OP_SHIFT);
         case (op)
            OP_LOAD:  stages <= par;
            OP_SHIFT: stages <= {stages[WIDTH-2:0], ser};
            default:  stages <= stages;
         endcase
      end
   end
endmodule

// File: rtl/psr_shift_top.sv
module psr_shift_top #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tap_clk_a,
   input  logic             tap_clk_b,
   input  logic             load_n,
   input  logic             ser_in,
   input  logic [WIDTH-1:0] par_in,
   output logic             last_q,
   output logic             last_qn,
   output logic             shift_pulse
);
   localparam int unsigned DW = WIDTH + 1;

   if (WIDTH < psr_pkg::MIN_WIDTH) begin : g_bad_width
      $error("psr_shift_top: WIDTH must be at least 2");
   end

   logic [1:0]       clk_s;
   logic             load_n_s;
   logic [DW-1:0]    data_s;
   logic             ser_s;
   logic [WIDTH-1:0] par_s;
   logic             rise;
   logic [WIDTH-1:0] stages;

   psr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d({tap_clk_b, tap_clk_a}), .q(clk_s));

   psr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ld (
      .clk(clk), .rst_n(rst_n), .d(load_n), .q(load_n_s));

   psr_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d({ser_in, par_in}), .q(data_s));

   assign ser_s = data_s[DW-1];
   assign par_s = data_s[WIDTH-1:0];

   psr_edge u_edge (
      .clk(clk), .rst_n(rst_n), .ca(clk_s[0]), .cb(clk_s[1]), .rise(rise));

   psr_stages #(.WIDTH(WIDTH)) u_stages (
      .clk(clk), .rst_n(rst_n), .load_n(load_n_s), .edge_hit(rise),
      .ser(ser_s), .par(par_s), .stages(stages), .shifted(shift_pulse));

   assign last_q  = stages[WIDTH-1];
   assign last_qn = ~stages[WIDTH-1];
endmodule

// File: rtl/psr_shift_chk.sv
module psr_shift_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n_s,
   input logic             rise,
   input logic             ca_s,
   input logic             cb_s,
   input logic             ser_s,
   input logic [WIDTH-1:0] par_s,
   input logic [WIDTH-1:0] stages,
   input logic             shift_pulse
);
   p_load_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n_s |=> stages == $past(par_s));

   p_shift_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n_s && rise) |=> stages == {$past(stages[WIDTH-2:0]), $past(ser_s)});

   p_inhibit_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ca_s && $past(ca_s)) |-> !rise);

   p_inhibit_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_s && $past(cb_s)) |-> !rise);

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n_s && !rise) |=> $stable(stages));

   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_pulse |=> !shift_pulse);

   p_load_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && rise) |=> !shift_pulse);
endmodule

bind psr_shift_top psr_shift_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .load_n_s(load_n_s), .rise(rise),
   .ca_s(clk_s[0]), .cb_s(clk_s[1]), .ser_s(ser_s), .par_s(par_s),
   .stages(stages), .shift_pulse(shift_pulse));

// File: tb/psr_shift_top_tb_top.sv
module psr_shift_top_tb_top;
   localparam int W = 8;
   localparam time CLK_P = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tap_clk_a = 1'b0, tap_clk_b = 1'b0, load_n = 1'b1, ser_in = 1'b0;
   logic [W-1:0] par_in = '0;
   logic last_q, last_qn, shift_pulse;

   int total = 0, bad = 0, pulses = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   psr_shift_top #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .tap_clk_a(tap_clk_a), .tap_clk_b(tap_clk_b),
      .load_n(load_n), .ser_in(ser_in), .par_in(par_in),
      .last_q(last_q), .last_qn(last_qn), .shift_pulse(shift_pulse));

   always @(posedge clk) if (rst_n && shift_pulse) pulses++;

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_pin(bit use_b);
      cyc(1);
      if (use_b) tap_clk_b = 1'b1; else tap_clk_a = 1'b1;
      cyc(4);
      if (use_b) tap_clk_b = 1'b0; else tap_clk_a = 1'b0;
      cyc(4);
   endtask

   task automatic do_load(logic [W-1:0] v);
      cyc(1);
      par_in = v; load_n = 1'b0;
      cyc(5);
      load_n = 1'b1;
      cyc(5);
   endtask

   task automatic t_reset;
      cyc(1);
      check("R1 last_q", last_q, 0);
      check("R1 last_qn", last_qn, 1);
      check("R1 shift_pulse", shift_pulse, 0);
   endtask

   task automatic t_load;
      int p0;
      p0 = pulses;
      cyc(1);
      par_in = 8'hA5; load_n = 1'b0;
      cyc(2);
      check("R2 latency before third edge", last_q, 0);
      cyc(1);
      check("R2 latency at third edge", last_q, 1);
      check("R6 inverse during load", last_qn, 0);
      par_in = 8'h35;
      cyc(5);
      check("R2 follows word while low", last_q, 0);
      tap_clk_a = 1'b1; cyc(5); tap_clk_a = 1'b0; cyc(5);
      check("R8 edge during load ignored", last_q, 0);
      check("R7 no pulse during load", pulses - p0, 0);
      load_n = 1'b1;
      cyc(5);
   endtask

   task automatic t_priority;
      int p0;
      cyc(1);
      p0 = pulses;
      par_in = 8'h80; load_n = 1'b0; tap_clk_b = 1'b1;
      cyc(5);
      load_n = 1'b1;
      cyc(5);
      tap_clk_b = 1'b0;
      cyc(5);
      check("R8 word kept on simultaneous edge", last_q, 1);
      check("R8 no shift counted", pulses - p0, 0);
   endtask

   task automatic t_walk;
      logic [W-1:0] v = 8'b1011_0010;
      int p0;
      ser_in = 1'b0;
      do_load(v);
      p0 = pulses;
      check("R9 first presented bit", last_q, int'(v[W-1]));
      for (int k = 1; k < W; k++) begin
         pulse_pin(1'b0);
         check("R9 walk bit", last_q, int'(v[W-1-k]));
         check("R6 inverse during walk", last_qn, int'(!v[W-1-k]));
      end
      check("R7 one pulse per shift", pulses - p0, W-1);
   endtask

   task automatic t_serial;
      logic [W-1:0] bits = 8'b1101_0110;
      do_load('0);
      for (int i = 0; i < W; i++) begin
         cyc(1); ser_in = bits[i]; cyc(4);
         pulse_pin(1'b1);
      end
      check("R3 first serial bit at last stage", last_q, int'(bits[0]));
      for (int i = 1; i < W; i++) begin
         cyc(1); ser_in = 1'b0; cyc(4);
         pulse_pin(1'b1);
         check("R3 serial order", last_q, int'(bits[i]));
      end
   endtask

   task automatic t_inhibit;
      int p0;
      do_load(8'h40);
      cyc(1); tap_clk_a = 1'b1; cyc(6);
      check("R3 shift on A rising", last_q, 1);
      p0 = pulses;
      for (int i = 0; i < 3; i++) pulse_pin(1'b1);
      check("R4 B pulses blocked by A high", pulses - p0, 0);
      check("R4 state kept", last_q, 1);
      cyc(1); tap_clk_b = 1'b1; cyc(5); tap_clk_a = 1'b0; cyc(5);
      tap_clk_b = 1'b0; cyc(5);
      check("R4 handover without shift", pulses - p0, 0);
      check("R4 last stage after handover", last_q, 1);
   endtask

   task automatic t_hold;
      int p0;
      do_load(8'h80);
      p0 = pulses;
      cyc(1); par_in = 8'h00; ser_in = 1'b1; cyc(20);
      check("R5 hold with inputs moving", last_q, 1);
      check("R5 no shift while idle", pulses - p0, 0);
   endtask

   task automatic t_reset_again;
      do_load(8'hFF);
      cyc(1); rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
      check("R1 reset clears loaded word", last_q, 0);
      check("R1 reset inverse", last_qn, 1);
   endtask

   initial begin
      cyc(4);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_priority();
      t_walk();
      t_serial();
      t_inhibit();
      t_hold();
      t_reset_again();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule